// File: doc/BRIEF.md
# Serial ADC Convert-and-Readout Sequencer

This block sits on the host side of a 12-bit successive-approximation converter with a four-wire serial port. It owns the conversion-start line, the serial clock and the serial data line into the converter, and it samples the converter's data output. Every accepted request runs one full cycle. First it reads out the result of the previous conversion, 12 bits MSB first, on the same 12 clock pulses that carry the 6-bit setup word for the next conversion. Then it waits for the inputs to settle, raises the start line, and waits out the worst-case conversion time.

A request carries four fields: single-ended or differential input, channel/polarity select, unipolar or bipolar coding, and the start-pulse shape. With a short pulse the start line drops after a few clocks and the converter stays powered. With a long pulse the start line stays high after the conversion, so the converter sleeps. The line is then dropped at the start of the next request, which wakes the converter and enables its output. Each result comes back as the raw 12-bit code and a 16-bit value. The 16-bit value is sign-extended when the conversion that produced the result was bipolar and zero-extended when it was unipolar.

Both data interfaces are valid/ready. A request transfers on a clock where `req_valid` and `req_ready` are both high. `req_ready` is high only when the sequencer is idle and no result is waiting. A result is held unchanged while `res_valid` is high and `res_ready` is low. It transfers on the first clock where both are high. Back-pressure on the result side therefore stalls new requests but never a conversion already under way.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset the start line, serial clock and serial data-in line are low, `res_valid` is low and `req_ready` is high.
- R2: The 6-bit setup word is driven on `adc_sdi` MSB first, one bit per serial-clock pulse. Its bits in send order are: single-ended flag, channel/polarity select, 0, 0, unipolar flag, 0. The remaining six pulses of the readout carry 0.
- R3: Each readout produces exactly 12 serial-clock pulses from an idle-low clock. Pulses occur only while the start line is low. `adc_sdo` is sampled at each rising edge, and the first sample becomes the code's MSB.
- R4: The result of each request is the code of the conversion started by the previous request. The first result after reset is reported as unipolar.
- R5: `res_unipolar` is the coding flag of the conversion that produced the result. `res_ext` equals `res_code` zero-extended to 16 bits when that flag is 1 and sign-extended from bit 11 when it is 0.
- R6: In short-pulse mode the start line is high for exactly PULSE_CYCLES clocks.
- R7: In long-pulse mode the start line stays high after the conversion time until the next request is accepted. It falls on that clock and stays low for EN_CYCLES clocks before the serial clock starts.
- R8: For CONV_CYCLES clocks from a start-line rise, no request is accepted and the serial clock stays low.
- R9: The start line rises no sooner than GAP_CYCLES clocks after the last serial-clock falling edge.
- R10: While `res_valid` is high and `res_ready` is low, `res_code`, `res_ext` and `res_unipolar` stay constant and `req_ready` stays low.
- R11: Within a readout the serial clock is high for SCK_HALF clocks and low for SCK_HALF clocks in every period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken this clock |
| req_single | input | 1 | 1 = single-ended input, 0 = differential pair |
| req_odd | input | 1 | Channel select (single-ended) or polarity select (differential) |
| req_unipolar | input | 1 | 1 = straight binary coding, 0 = two's complement |
| req_long | input | 1 | 1 = long start pulse (sleep between cycles), 0 = short pulse |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Result consumer ready |
| res_code | output | 12 | Raw code of the previous conversion |
| res_ext | output | 16 | Code extended to 16 bits per its coding |
| res_unipolar | output | 1 | Coding of the conversion that produced the result |
| adc_convst | output | 1 | Conversion start line to the converter |
| adc_sck | output | 1 | Serial clock to the converter |
| adc_sdi | output | 1 | Setup word to the converter |
| adc_sdo | input | 1 | Serial data from the converter |

## Verification
Suppose the sequencer's bit counter or state lost track. At the next start-line rise the pulse count would be off by one or more, so the converter would see a truncated setup word and the result would come back shifted. Both faults show within the same cycle. A slip in the pairing of coding flag and result appears in `res_ext` on the following result, when a negative bipolar code loses its sign bits. A timer running short shows up as serial-clock activity or an accepted request inside the conversion window, tens of clocks before the converter would really finish.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  localparam int SETUP_BITS = 6;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAKE,
    ST_SHIFT,
    ST_GAP,
    ST_CONV
  } seq_state_t;

  // Setup word in send order (bit 5 goes out first); spare bits are zero.
  function automatic logic [SETUP_BITS-1:0] make_setup(input logic single_end,
                                                       input logic odd_sel,
                                                       input logic unipolar);
    return {single_end, odd_sel, 1'b0, 1'b0, unipolar, 1'b0};
  endfunction

endpackage

// File: rtl/adc_sck_shifter.sv
module adc_sck_shifter #(
  parameter int SCK_HALF = 2,
  parameter int DATA_W   = 12,
  parameter int SETUP_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [SETUP_W-1:0] setup_word,
  input  logic              sdo,
  output logic              sck,
  output logic              sdi,
  output logic [DATA_W-1:0] data,
  output logic              done
);

  localparam int HW = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;
  localparam int BW = $clog2(DATA_W + 1);

  logic               active;
  logic [HW-1:0]      half_cnt;
  logic [BW-1:0]      bit_cnt;
  logic [SETUP_W-1:0] setup_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      half_cnt <= '0;
      bit_cnt  <= '0;
      setup_q  <= '0;
      sck      <= 1'b0;
      sdi      <= 1'b0;
      data     <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        active   <= 1'b1;
        half_cnt <= '0;
        bit_cnt  <= '0;
        setup_q  <= setup_word << 1;
        sdi      <= setup_word[SETUP_W-1];
        sck      <= 1'b0;
      end else if (active) begin
        if (half_cnt == HW'(SCK_HALF - 1)) begin
          half_cnt <= '0;
          if (!sck) begin
            // rising edge: capture the bit the converter is presenting
            sck  <= 1'b1;
            data <= {data[DATA_W-2:0], sdo};
          end else begin
            // falling edge: advance to the next outgoing bit
            sck     <= 1'b0;
            sdi     <= setup_q[SETUP_W-1];
            setup_q <= setup_q << 1;
            bit_cnt <= bit_cnt + 1'b1;
            if (bit_cnt == BW'(DATA_W - 1)) begin
              active <= 1'b0;
              done   <= 1'b1;
              sdi    <= 1'b0;
            end
          end
        end else begin
          half_cnt <= half_cnt + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/adc_result_fmt.sv
module adc_result_fmt #(
  parameter int DATA_W = 12,
  parameter int EXT_W  = 16
) (
  input  logic [DATA_W-1:0] code,
  input  logic              unipolar,
  output logic [EXT_W-1:0]  ext
);

  localparam int PAD_W = EXT_W - DATA_W;

  always_comb begin
    if (unipolar) ext = {{PAD_W{1'b0}}, code};
    else          ext = {{PAD_W{code[DATA_W-1]}}, code};
  end

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int SCK_HALF     = 2,
  parameter int CONV_CYCLES  = 165,
  parameter int PULSE_CYCLES = 3,
  parameter int GAP_CYCLES   = 3,
  parameter int EN_CYCLES    = 2,
  parameter int DATA_W       = 12,
  parameter int EXT_W        = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_single,
  input  logic              req_odd,
  input  logic              req_unipolar,
  input  logic              req_long,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [DATA_W-1:0] res_code,
  output logic [EXT_W-1:0]  res_ext,
  output logic              res_unipolar,
  output logic              adc_convst,
  output logic              adc_sck,
  output logic              adc_sdi,
  input  logic              adc_sdo
);

  localparam int M1   = (CONV_CYCLES > GAP_CYCLES) ? CONV_CYCLES : GAP_CYCLES;
  localparam int M2   = (M1 > EN_CYCLES) ? M1 : EN_CYCLES;
  localparam int MAXC = (M2 > PULSE_CYCLES) ? M2 : PULSE_CYCLES;
  localparam int TW   = $clog2(MAXC + 1);

  seq_state_t             state;
  logic [TW-1:0]          tmr;
  logic [SETUP_BITS-1:0]  setup_q;
  logic                   long_q;
  logic                   uni_next;
  logic                   uni_prev;
  logic                   shift_start;
  logic                   shift_done;
  logic [DATA_W-1:0]      shift_data;

  assign req_ready   = (state == ST_IDLE) && !res_valid;
  assign shift_start = (state == ST_WAKE) && (tmr == TW'(EN_CYCLES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      tmr          <= '0;
      setup_q      <= '0;
      long_q       <= 1'b0;
      uni_next     <= 1'b1;
      uni_prev     <= 1'b1;
      adc_convst   <= 1'b0;
      res_valid    <= 1'b0;
      res_code     <= '0;
      res_unipolar <= 1'b1;
    end else begin
      if (res_valid && res_ready) res_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid && req_ready) begin
            setup_q    <= make_setup(req_single, req_odd, req_unipolar);
            long_q     <= req_long;
            uni_next   <= req_unipolar;
            adc_convst <= 1'b0;  // wakes a sleeping converter, enables its output
            tmr        <= '0;
            state      <= ST_WAKE;
          end
        end
        ST_WAKE: begin
          tmr <= tmr + 1'b1;
          if (shift_start) state <= ST_SHIFT;
        end
        ST_SHIFT: begin
          if (shift_done) begin
            res_valid    <= 1'b1;
            res_code     <= shift_data;
            res_unipolar <= uni_prev;
            uni_prev     <= uni_next;
            tmr          <= '0;
            state        <= ST_GAP;
          end
        end
        ST_GAP: begin
          tmr <= tmr + 1'b1;
          if (tmr == TW'(GAP_CYCLES - 1)) begin
            adc_convst <= 1'b1;
            tmr        <= '0;
            state      <= ST_CONV;
          end
        end
        ST_CONV: begin
          tmr <= tmr + 1'b1;
          if (!long_q && tmr == TW'(PULSE_CYCLES - 1)) adc_convst <= 1'b0;
          if (tmr == TW'(CONV_CYCLES - 1)) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  adc_sck_shifter #(
    .SCK_HALF (SCK_HALF),
    .DATA_W   (DATA_W),
    .SETUP_W  (SETUP_BITS)
  ) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (shift_start),
    .setup_word (setup_q),
    .sdo        (adc_sdo),
    .sck        (adc_sck),
    .sdi        (adc_sdi),
    .data       (shift_data),
    .done       (shift_done)
  );

  adc_result_fmt #(
    .DATA_W (DATA_W),
    .EXT_W  (EXT_W)
  ) u_fmt (
    .code     (res_code),
    .unipolar (res_unipolar),
    .ext      (res_ext)
  );

endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
  parameter int CONV_CYCLES  = 165,
  parameter int PULSE_CYCLES = 3,
  parameter int GAP_CYCLES   = 3,
  parameter int DATA_W       = 12,
  parameter int EXT_W        = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              convst,
  input logic              sck,
  input logic              req_ready,
  input logic              res_valid,
  input logic              res_ready,
  input logic [DATA_W-1:0] res_code,
  input logic [EXT_W-1:0]  res_ext,
  input logic              res_unipolar,
  input logic              long_q
);

  logic        cv_d, sck_d, pulse_long;
  logic [15:0] conv_cnt, hi_cnt, gap_cnt;
  logic [7:0]  rise_cnt;
  logic        cv_rise, busy;

  assign cv_rise = convst && !cv_d;
  assign busy    = cv_rise || (conv_cnt < 16'(CONV_CYCLES));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cv_d       <= 1'b0;
      sck_d      <= 1'b0;
      pulse_long <= 1'b0;
      conv_cnt   <= 16'(CONV_CYCLES);
      hi_cnt     <= '0;
      gap_cnt    <= 16'hFFFF;
      rise_cnt   <= '0;
    end else begin
      cv_d  <= convst;
      sck_d <= sck;
      if (cv_rise) begin
        conv_cnt   <= 16'd1;
        pulse_long <= long_q;
        rise_cnt   <= '0;
      end else begin
        if (conv_cnt < 16'(CONV_CYCLES)) conv_cnt <= conv_cnt + 16'd1;
        if (sck && !sck_d) rise_cnt <= rise_cnt + 8'd1;
      end
      if (!convst)                hi_cnt <= '0;
      else if (hi_cnt != 16'hFFFF) hi_cnt <= hi_cnt + 16'd1;
      if (sck)                     gap_cnt <= '0;
      else if (gap_cnt != 16'hFFFF) gap_cnt <= gap_cnt + 16'd1;
    end
  end

  assert_sck_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
    convst |-> !sck);

  assert_pulse_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cv_rise |-> (rise_cnt == 8'(DATA_W)));

  assert_ext_format_R5: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_ext[DATA_W-1:0] == res_code) &&
      (res_ext[EXT_W-1:DATA_W] ==
        (res_unipolar ? '0 : {(EXT_W-DATA_W){res_code[DATA_W-1]}})));

  assert_short_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!convst && cv_d && !pulse_long) |-> (hi_cnt == 16'(PULSE_CYCLES)));

  assert_conv_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!req_ready && !sck));

  assert_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cv_rise |-> (gap_cnt >= 16'(GAP_CYCLES)));

  assert_hold_result_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_code) && $stable(res_unipolar)));

endmodule

bind adc_seq_ctrl adc_seq_chk #(
  .CONV_CYCLES  (CONV_CYCLES),
  .PULSE_CYCLES (PULSE_CYCLES),
  .GAP_CYCLES   (GAP_CYCLES),
  .DATA_W       (DATA_W),
  .EXT_W        (EXT_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .convst       (adc_convst),
  .sck          (adc_sck),
  .req_ready    (req_ready),
  .res_valid    (res_valid),
  .res_ready    (res_ready),
  .res_code     (res_code),
  .res_ext      (res_ext),
  .res_unipolar (res_unipolar),
  .long_q       (long_q)
);

// File: tb/tb_adc_seq_ctrl.sv
module tb_adc_seq_ctrl;

  localparam int SCK_HALF     = 2;
  localparam int CONV_CYCLES  = 165;
  localparam int PULSE_CYCLES = 3;
  localparam int GAP_CYCLES   = 3;
  localparam int EN_CYCLES    = 2;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_single = 1'b0, req_odd = 1'b0;
  logic        req_unipolar = 1'b0, req_long = 1'b0, res_ready = 1'b1;
  logic        req_ready, res_valid, res_unipolar;
  logic [11:0] res_code;
  logic [15:0] res_ext;
  logic        adc_convst, adc_sck, adc_sdi, adc_sdo;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  always @(posedge clk) cyc <= cyc + 1;

  adc_seq_ctrl dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_single(req_single), .req_odd(req_odd),
    .req_unipolar(req_unipolar), .req_long(req_long),
    .res_valid(res_valid), .res_ready(res_ready),
    .res_code(res_code), .res_ext(res_ext), .res_unipolar(res_unipolar),
    .adc_convst(adc_convst), .adc_sck(adc_sck), .adc_sdi(adc_sdi), .adc_sdo(adc_sdo)
  );

  // ---------------- converter model ----------------
  logic [11:0] analog = '0, adc_word = '0;
  logic [5:0]  setup_sh = '0, setup_conv = '0;
  int          sdi_n = 0, out_idx = 0, err_spare = 0;
  logic        a_sck_p = 1'b0, a_cv_p = 1'b0;

  assign adc_sdo = (adc_convst || out_idx > 11) ? 1'b0 : adc_word[11 - out_idx];

  always @(negedge clk) begin
    if (adc_sck && !a_sck_p) begin
      if (sdi_n < 6) setup_sh = {setup_sh[4:0], adc_sdi};
      else if (adc_sdi) err_spare++;
      sdi_n++;
    end
    if (!adc_sck && a_sck_p) out_idx++;
    if (adc_convst && !a_cv_p) begin
      adc_word   = analog;
      setup_conv = setup_sh;
      out_idx    = 0;
      sdi_n      = 0;
    end
    a_sck_p = adc_sck;
    a_cv_p  = adc_convst;
  end

  // ---------------- timing monitor ----------------
  int   t_rise = -1000000, hi_run = 0, last_hi = 0, burst = 0, last_burst = 0;
  int   sck_hi = 0, sck_lo = 0, gap_run = 1000000;
  int   err_half = 0, err_conv = 0, err_gap = 0, err_sckcv = 0;
  logic m_cv = 1'b0, m_sck = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (adc_convst) hi_run++;
      if (adc_convst && !m_cv) begin
        t_rise     = cyc;
        last_burst = burst;
        burst      = 0;
        if (gap_run < GAP_CYCLES) err_gap++;
      end
      if (!adc_convst && m_cv) begin
        last_hi = hi_run;
        hi_run  = 0;
      end
      if (adc_sck && adc_convst) err_sckcv++;
      if (adc_sck) begin
        if (!m_sck) begin
          if (burst > 0 && sck_lo != SCK_HALF) err_half++;
          if (cyc - t_rise < CONV_CYCLES) err_conv++;
          burst++;
          sck_hi = 1;
        end else sck_hi++;
      end else begin
        if (m_sck) begin
          if (sck_hi != SCK_HALF) err_half++;
          sck_lo  = 1;
          gap_run = 1;
        end else begin
          sck_lo++;
          gap_run++;
        end
      end
      if (req_valid && req_ready && (cyc - t_rise) < CONV_CYCLES) err_conv++;
      m_cv  = adc_convst;
      m_sck = adc_sck;
    end
  end

  // ---------------- helpers ----------------
  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] ext_of(input logic [11:0] c, input bit uni);
    return uni ? {4'h0, c} : {{4{c[11]}}, c};
  endfunction

  logic [11:0] prev_word = '0;
  bit          prev_uni  = 1'b1;

  task automatic send_req(input bit s, input bit o, input bit u, input bit l);
    @(negedge clk);
    req_single = s; req_odd = o; req_unipolar = u; req_long = l;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic check_result(input string tag);
    check(res_code == prev_word, {tag, " R4 code"}, res_code, prev_word);
    check(res_unipolar == prev_uni, {tag, " R5 coding flag"}, res_unipolar, prev_uni);
    check(res_ext == ext_of(prev_word, prev_uni), {tag, " R5 extension"}, res_ext,
          ext_of(prev_word, prev_uni));
  endtask

  task automatic check_after(input bit s, input bit o, input bit u, input bit l);
    check(setup_conv == {s, o, 2'b00, u, 1'b0}, "R2 setup word", setup_conv, {s, o, 2'b00, u, 1'b0});
    check(last_burst == 12, "R3 pulses per readout", last_burst, 12);
    if (!l) check(last_hi == PULSE_CYCLES, "R6 short pulse width", last_hi, PULSE_CYCLES);
    else    check(adc_convst == 1'b1, "R7 start line held high", adc_convst, 1);
  endtask

  // one full convert/readout cycle; hold keeps req_valid up through the conversion
  task automatic run_cycle(input bit s, input bit o, input bit u, input bit l,
                           input logic [11:0] an, input bit hold);
    int bad;
    analog = an;
    send_req(s, o, u, l);
    if (!hold) req_valid = 1'b0;
    while (!res_valid) @(negedge clk);
    check_result("cycle");
    if (hold) begin
      while (!adc_convst) @(negedge clk);
      bad = 0;
      for (int i = 0; i < CONV_CYCLES; i++) begin
        if (req_ready || adc_sck) bad++;
        if (i == CONV_CYCLES - 1) req_valid = 1'b0;
        else @(negedge clk);
      end
      check(bad == 0, "R8 request ignored during conversion", bad, 0);
    end
    while (!req_ready) @(negedge clk);
    check_after(s, o, u, l);
    prev_word = an;
    prev_uni  = u;
  endtask

  task automatic test_reset();
    check(adc_convst == 0, "R1 start line low", adc_convst, 0);
    check(adc_sck == 0 && adc_sdi == 0, "R1 serial lines low", {adc_sck, adc_sdi}, 0);
    check(res_valid == 0, "R1 no result", res_valid, 0);
    check(req_ready == 1, "R1 ready", req_ready, 1);
  endtask

  task automatic test_long_sleep();
    int bad = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (!adc_convst) bad++;
    end
    check(bad == 0, "R7 start line stays high while idle", bad, 0);
  endtask

  task automatic test_backpressure(input logic [11:0] an);
    logic [11:0] held;
    int          bad = 0;
    res_ready = 1'b0;
    analog = an;
    send_req(1'b1, 1'b0, 1'b0, 1'b0);
    req_valid = 1'b0;
    while (!res_valid) @(negedge clk);
    held = res_code;
    check_result("backpressure");
    for (int i = 0; i < CONV_CYCLES + 40; i++) begin
      @(negedge clk);
      if (!res_valid || res_code != held || req_ready) bad++;
    end
    check(bad == 0, "R10 result held and requests stalled", bad, 0);
    res_ready = 1'b1;
    @(negedge clk);
    check(res_valid == 0, "R10 handshake completes", res_valid, 0);
    while (!req_ready) @(negedge clk);
    check_after(1'b1, 1'b0, 1'b0, 1'b0);
    prev_word = an;
    prev_uni  = 1'b0;
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  // ---------------- main ----------------
  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    test_reset();

    run_cycle(1'b1, 1'b0, 1'b1, 1'b0, 12'hABC, 1'b0);  // first result after reset
    run_cycle(1'b0, 1'b1, 1'b0, 1'b0, 12'h800, 1'b0);
    run_cycle(1'b1, 1'b1, 1'b0, 1'b1, 12'h7FF, 1'b0);  // long pulse
    test_long_sleep();
    run_cycle(1'b0, 1'b0, 1'b1, 1'b0, 12'h123, 1'b1);  // wake, request held during conversion
    test_backpressure(12'hFFF);
    run_cycle(1'b0, 1'b1, 1'b1, 1'b1, 12'h001, 1'b0);  // negative bipolar result
    run_cycle(1'b1, 1'b0, 1'b1, 1'b0, 12'h000, 1'b0);  // wake from long
    run_cycle(1'b1, 1'b1, 1'b0, 1'b0, 12'h5A5, 1'b0);

    check(err_spare == 0, "R2 spare bits zero", err_spare, 0);
    check(err_sckcv == 0, "R3 no clock with start line high", err_sckcv, 0);
    check(err_conv == 0, "R8 conversion window quiet", err_conv, 0);
    check(err_gap == 0, "R9 gap before start", err_gap, 0);
    check(err_half == 0, "R11 clock half periods", err_half, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule